// File: doc/BRIEF.md
# Activity Monitor Counter Bank

Each core has one of these counter banks for system-management telemetry. It holds two groups of wide event counters. The fixed group has four counters. Each is tied to one architectural event: core clock cycles, reference ticks at a constant rate, retired instructions, and dispatch stall cycles caused by misses in the last-level cache. The auxiliary group holds up to sixteen counters, and each of them follows one platform event input. Every counter has its own enable bit. Counting stops completely while the core sits in wait-for-interrupt or wait-for-event idle.

Software reaches the counters through one register port, addressed by group and index. A read returns its data one cycle after the request, together with a valid strobe. A write loads a counter, for example to restore it after power-down. Accesses made from the lowest privilege level raise a trap flag and return no data, unless the user-access control input is set. Each counter wraps to zero and, when it does, gives a one-cycle overflow pulse.

Top module: `actmon_bank`

## Requirements
- R1: After cold reset (rst_n low), every counter in both groups is zero, both enable registers are zero, and rd_valid, trap, ovf_fix and ovf_aux are low.
- R2: An enabled fixed counter advances by one on each clock edge where its event holds and idle is low. The events by index are: 0 on every clock, 1 on ref_tick, 2 on ev_retire, 3 on ev_stall.
- R3: Enabled auxiliary counter k advances by one on each clock edge where aux_ev[k] is high and idle is low.
- R4: While idle is high, no counter changes except through a register write.
- R5: A counter whose enable bit is clear reads as zero. It does not advance and ignores writes, but it keeps its value, and that value reads back again once the bit is set. An en_we pulse loads en_wdata[3:0] into the fixed-group enable register when en_grp=0. When en_grp=1 it loads en_wdata[NAUX-1:0] into the auxiliary-group enable register.
- R6: A granted read request (acc_req=1, acc_we=0) gives rd_valid high on the next cycle. rd_data then holds the counter's value as it stood at the request edge. When no read was granted, rd_valid is low.
- R7: Fixed-group indices 4 to 15 and auxiliary indices NAUX and above read as zero, and writes to them change no counter.
- R8: A granted write (acc_req=1, acc_we=1) to an enabled counter loads acc_wdata. It wins over an increment in the same cycle.
- R9: A request with acc_user=1 while user_acc_en=0 gives trap high for one cycle on the next cycle. In that case rd_valid stays low and any write is discarded. With user_acc_en=1 such a request behaves like any other.
- R10: A counter at all-ones that increments becomes zero. Its bit in ovf_fix or ovf_aux is high for exactly the cycle in which the counter first reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Cold reset, active low |
| idle | input | 1 | Core is in wait-for-interrupt or wait-for-event idle |
| ref_tick | input | 1 | Constant-rate reference tick enable |
| ev_retire | input | 1 | Instruction retired this cycle |
| ev_stall | input | 1 | Dispatch stalled on a last-level cache miss |
| aux_ev | input | NAUX | Platform event inputs, one per auxiliary counter |
| en_we | input | 1 | Enable register write strobe |
| en_grp | input | 1 | Enable register select: 0 fixed, 1 auxiliary |
| en_wdata | input | 16 | Enable register write value |
| acc_req | input | 1 | Counter access request |
| acc_we | input | 1 | Access is a write |
| acc_grp | input | 1 | Counter group: 0 fixed, 1 auxiliary |
| acc_idx | input | 4 | Counter index within the group |
| acc_wdata | input | CW | Counter write value |
| acc_user | input | 1 | Access comes from the lowest privilege level |
| user_acc_en | input | 1 | Lowest privilege level may access the counters |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | CW | Read data |
| trap | output | 1 | Access was refused and trapped |
| ovf_fix | output | 4 | Wrap pulse per fixed counter |
| ovf_aux | output | NAUX | Wrap pulse per auxiliary counter |

## Verification
The bench builds the bank with NAUX=4 and the full 64-bit counter width. With this setting, a sweep of all 32 group and index pairs covers both the unused fixed indices and the auxiliary indices past the implemented count. Because counters are restored to all-ones through the write port, the 64-bit wrap and its overflow pulses can be reached in a single cycle. All expected counts come from event patterns the bench chooses itself, tallied per cycle against its own copy of the enable bits.

// File: rtl/actmon_bank.sv
module actmon_bank #(
  parameter int CW   = 64,
  parameter int NAUX = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle,
  input  logic            ref_tick,
  input  logic            ev_retire,
  input  logic            ev_stall,
  input  logic [NAUX-1:0] aux_ev,
  input  logic            en_we,
  input  logic            en_grp,
  input  logic [15:0]     en_wdata,
  input  logic            acc_req,
  input  logic            acc_we,
  input  logic            acc_grp,
  input  logic [3:0]      acc_idx,
  input  logic [CW-1:0]   acc_wdata,
  input  logic            acc_user,
  input  logic            user_acc_en,
  output logic            rd_valid,
  output logic [CW-1:0]   rd_data,
  output logic            trap,
  output logic [3:0]      ovf_fix,
  output logic [NAUX-1:0] ovf_aux
);
  localparam int NFIX = 4;
  localparam int IW   = 4;

  logic [CW-1:0]   fix_q [NFIX];
  logic [CW-1:0]   aux_q [NAUX];
  logic [NFIX-1:0] fen_q;
  logic [NAUX-1:0] aen_q;
  logic [NFIX-1:0] fix_ev;
  logic [CW-1:0]   rd_mux;

  wire denied  = acc_req && acc_user && !user_acc_en;
  wire granted = acc_req && !denied;
  wire wr_go   = granted && acc_we;
  wire rd_go   = granted && !acc_we;

  assign fix_ev = {ev_stall, ev_retire, ref_tick, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q <= '0;
      aen_q <= '0;
    end else if (en_we) begin
      if (!en_grp) fen_q <= en_wdata[NFIX-1:0];
      else         aen_q <= en_wdata[NAUX-1:0];
    end
  end

  for (genvar i = 0; i < NFIX; i++) begin : g_fix
    wire wsel = wr_go && !acc_grp && acc_idx == IW'(i) && fen_q[i];
    wire inc  = fen_q[i] && !idle && fix_ev[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fix_q[i]   <= '0;
        ovf_fix[i] <= 1'b0;
      end else begin
        ovf_fix[i] <= 1'b0;
        if (wsel) fix_q[i] <= acc_wdata;
        else if (inc) begin
          fix_q[i]   <= fix_q[i] + CW'(1);
          ovf_fix[i] <= &fix_q[i];
        end
      end
    end

    // R4
    fix_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle && !(acc_req && acc_we) |=> $stable(fix_q[i]));
    // R5
    fix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fen_q[i] && !(en_we && !en_grp) |=> $stable(fix_q[i]));
    // R10
    fix_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_fix[i] |-> fix_q[i] == '0);
  end

  for (genvar k = 0; k < NAUX; k++) begin : g_aux
    wire wsel = wr_go && acc_grp && acc_idx == IW'(k) && aen_q[k];
    wire inc  = aen_q[k] && !idle && aux_ev[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        aux_q[k]   <= '0;
        ovf_aux[k] <= 1'b0;
      end else begin
        ovf_aux[k] <= 1'b0;
        if (wsel) aux_q[k] <= acc_wdata;
        else if (inc) begin
          aux_q[k]   <= aux_q[k] + CW'(1);
          ovf_aux[k] <= &aux_q[k];
        end
      end
    end

    // R4
    aux_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idle && !(acc_req && acc_we) |=> $stable(aux_q[k]));
    // R10
    aux_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_aux[k] |-> aux_q[k] == '0);
  end

  always_comb begin
    rd_mux = '0;
    if (!acc_grp) begin
      for (int i = 0; i < NFIX; i++)
        if (acc_idx == IW'(i) && fen_q[i]) rd_mux = fix_q[i];
    end else begin
      for (int k = 0; k < NAUX; k++)
        if (acc_idx == IW'(k) && aen_q[k]) rd_mux = aux_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      trap     <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      rd_data  <= rd_go ? rd_mux : '0;
      trap     <= denied;
    end
  end

  // R9
  trap_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && acc_user && !user_acc_en |=> trap && !rd_valid);
  // R9
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !rd_valid);
  // R6
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req && !acc_we && !(acc_user && !user_acc_en) |=> rd_valid);
  // R6
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |=> !rd_valid && !trap);
endmodule

// File: tb/actmon_bank_test.sv
module actmon_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 4;
  localparam int W  = 64;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n, idle, ref_tick, ev_retire, ev_stall;
  logic [NA-1:0] aux_ev;
  logic          en_we, en_grp;
  logic [15:0]   en_wdata;
  logic          acc_req, acc_we, acc_grp;
  logic [3:0]    acc_idx;
  logic [W-1:0]  acc_wdata;
  logic          acc_user, user_acc_en;
  logic          rd_valid, trap;
  logic [W-1:0]  rd_data;
  logic [3:0]    ovf_fix;
  logic [NA-1:0] ovf_aux;

  actmon_bank #(.CW(W), .NAUX(NA)) uut (
    .clk(clk), .rst_n(rst_n), .idle(idle), .ref_tick(ref_tick),
    .ev_retire(ev_retire), .ev_stall(ev_stall), .aux_ev(aux_ev),
    .en_we(en_we), .en_grp(en_grp), .en_wdata(en_wdata),
    .acc_req(acc_req), .acc_we(acc_we), .acc_grp(acc_grp), .acc_idx(acc_idx),
    .acc_wdata(acc_wdata), .acc_user(acc_user), .user_acc_en(user_acc_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .trap(trap),
    .ovf_fix(ovf_fix), .ovf_aux(ovf_aux)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0]  e0 [4];
  logic [W-1:0]  e1 [NA];
  logic [3:0]    en0_m;
  logic [NA-1:0] en1_m;

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_of(int g, int idx);
    if (g == 0) return (idx < 4 && en0_m[idx]) ? e0[idx] : '0;
    return (idx < NA && en1_m[idx]) ? e1[idx] : '0;
  endfunction

  task automatic set_en(bit g, logic [15:0] v);
    en_we = 1'b1; en_grp = g; en_wdata = v;
    @(negedge clk);
    en_we = 1'b0;
    if (g == 0) en0_m = v[3:0]; else en1_m = v[NA-1:0];
  endtask

  task automatic do_read(bit g, int idx, string tag);
    acc_req = 1'b1; acc_we = 1'b0; acc_grp = g; acc_idx = 4'(idx);
    @(negedge clk);
    acc_req = 1'b0;
    check($sformatf("%s valid g%0d i%0d", tag, g, idx), W'(rd_valid), W'(1));
    check($sformatf("%s data g%0d i%0d", tag, g, idx), rd_data, exp_of(g, idx));
  endtask

  task automatic do_write(bit g, int idx, logic [W-1:0] v);
    acc_req = 1'b1; acc_we = 1'b1; acc_grp = g; acc_idx = 4'(idx); acc_wdata = v;
    @(negedge clk);
    acc_req = 1'b0; acc_we = 1'b0;
    if (g == 0 && idx < 4 && en0_m[idx]) e0[idx] = v;
    if (g == 1 && idx < NA && en1_m[idx]) e1[idx] = v;
  endtask

  task automatic sweep(string tag);
    for (int g = 0; g < 2; g++)
      for (int i = 0; i < 16; i++) do_read(g[0], i, tag);
  endtask

  task automatic run_cycle(bit rt, bit re, bit st, logic [NA-1:0] ax);
    idle = 1'b0; ref_tick = rt; ev_retire = re; ev_stall = st; aux_ev = ax;
    if (en0_m[0]) e0[0] = e0[0] + 1;
    if (en0_m[1] && rt) e0[1] = e0[1] + 1;
    if (en0_m[2] && re) e0[2] = e0[2] + 1;
    if (en0_m[3] && st) e0[3] = e0[3] + 1;
    for (int k = 0; k < NA; k++) if (en1_m[k] && ax[k]) e1[k] = e1[k] + 1;
    @(negedge clk);
    idle = 1'b1; ref_tick = 1'b0; ev_retire = 1'b0; ev_stall = 1'b0; aux_ev = '0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    rst_n = 1'b0; idle = 1'b1; ref_tick = 0; ev_retire = 0; ev_stall = 0; aux_ev = '0;
    en_we = 0; en_grp = 0; en_wdata = '0; acc_req = 0; acc_we = 0; acc_grp = 0;
    acc_idx = '0; acc_wdata = '0; acc_user = 0; user_acc_en = 0;
    en0_m = '0; en1_m = '0;
    for (int i = 0; i < 4; i++) e0[i] = '0;
    for (int k = 0; k < NA; k++) e1[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: outputs quiet after reset, all counters zero
    check("R1 rd_valid", W'(rd_valid), '0);
    check("R1 trap", W'(trap), '0);
    check("R1 ovf", W'({ovf_fix, ovf_aux}), '0);
    sweep("R1 enables clear");
    set_en(0, 16'h000f);
    set_en(1, 16'h000f);
    sweep("R1 counters zero");

    // R2 R3: patterned events
    for (int c = 0; c < 40; c++)
      run_cycle(c % 3 == 0, c % 2 == 0, c % 5 == 0, NA'(c ^ (c >> 1)));
    check("R2 cycle count", e0[0], W'(40));
    check("R10 no ovf", W'({ovf_fix, ovf_aux}), '0);
    sweep("R2 R3 R7 counts");

    // R4: idle with all events high
    ref_tick = 1; ev_retire = 1; ev_stall = 1; aux_ev = '1;
    repeat (10) @(negedge clk);
    ref_tick = 0; ev_retire = 0; ev_stall = 0; aux_ev = '0;
    sweep("R4 idle frozen");

    // R5: disabled counters read zero, hold, resume
    set_en(0, 16'h000b);
    set_en(1, 16'h000d);
    do_read(0, 2, "R5 disabled fix");
    do_read(1, 1, "R5 disabled aux");
    for (int c = 0; c < 5; c++) run_cycle(1, 1, 1, '1);
    set_en(0, 16'h000f);
    set_en(1, 16'h000f);
    sweep("R5 retained");

    // R8: write wins over increment
    idle = 1'b0; ref_tick = 1'b1;
    acc_req = 1'b1; acc_we = 1'b1; acc_grp = 1'b0; acc_idx = 4'd1; acc_wdata = 64'h1234;
    e0[0] = e0[0] + 1; e0[1] = 64'h1234;
    @(negedge clk);
    idle = 1'b1; ref_tick = 1'b0; acc_req = 1'b0; acc_we = 1'b0;
    do_read(0, 1, "R8 write priority");
    do_read(0, 0, "R8 neighbour counts");
    set_en(1, 16'h000b);
    do_write(1, 2, 64'd99);
    set_en(1, 16'h000f);
    do_read(1, 2, "R8 disabled write ignored");
    do_write(1, 0, 64'hdead_beef_0000_0001);
    do_read(1, 0, "R8 aux write");

    // R7: writes to unimplemented indices
    do_write(0, 7, '1);
    do_write(1, 6, '1);
    do_write(1, 15, '1);
    sweep("R7 unimplemented");

    // R9: user access trapped
    acc_user = 1'b1; user_acc_en = 1'b0;
    acc_req = 1'b1; acc_we = 1'b0; acc_grp = 1'b1; acc_idx = 4'd0;
    @(negedge clk);
    acc_req = 1'b0;
    check("R9 trap raised", W'(trap), W'(1));
    check("R9 no valid", W'(rd_valid), '0);
    @(negedge clk);
    check("R9 trap one cycle", W'(trap), '0);
    acc_req = 1'b1; acc_we = 1'b1; acc_grp = 1'b1; acc_idx = 4'd0; acc_wdata = 64'h55;
    @(negedge clk);
    acc_req = 1'b0; acc_we = 1'b0;
    check("R9 write trapped", W'(trap), W'(1));
    acc_user = 1'b0;
    do_read(1, 0, "R9 trapped write discarded");
    acc_user = 1'b1; user_acc_en = 1'b1;
    do_read(0, 2, "R9 user allowed");
    check("R9 no trap when allowed", W'(trap), '0);
    acc_user = 1'b0; user_acc_en = 1'b0;

    // R10: wrap and overflow pulses
    do_write(0, 0, '1);
    do_write(1, 3, '1);
    run_cycle(0, 0, 0, NA'(8));
    check("R10 ovf_fix", W'(ovf_fix), W'(4'b0001));
    check("R10 ovf_aux", W'(ovf_aux), W'(8));
    @(negedge clk);
    check("R10 ovf pulse ends", W'({ovf_fix, ovf_aux}), '0);
    do_read(0, 0, "R10 wrapped fix");
    do_read(1, 3, "R10 wrapped aux");

    report();
  end
endmodule